// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Wakeup

This block holds renamed instructions between dispatch and execution in an out-of-order core. Each dispatched instruction carries an 8-bit sequence number, a class (integer, floating point or branch), up to two physical source tags and an optional destination tag. An entry waits until both of its sources are available. A per-register availability scoreboard covers one unified physical index space in which the floating-point registers follow the integer ones.

Every cycle the queue picks ready entries oldest-first. Each class has its own per-cycle cap, and a shared total cap also applies. Picked entries appear on numbered issue slots and leave the queue at the same clock edge. A completion (wakeup) tag makes its register available and releases the waiting operands. A squash removes every entry younger than a given sequence number. It takes precedence over issue and dispatch in that cycle.

The rename stage, the execution units and commit sit outside the block and reach it only through the ports.

Top module: `iq_issue_queue`

## Requirements
- R1: After reset the queue is empty. free_cnt is 16, full is 0, no issue slot is valid, and every scoreboard bit reads available.
- R2: A dispatch is accepted when disp_valid is 1, the queue is not full and squash_valid is 0. The instruction occupies an entry from the next cycle. full is 1 exactly when all 16 entries are occupied, and a dispatch offered while full is dropped. free_cnt equals 16 minus the occupied entries.
- R3: Tags 0 to 95 name integer registers and tags 96 to 191 name floating-point registers. An accepted dispatch with disp_dst_vld clears the scoreboard bit of disp_dst. A wakeup sets the bit of wk_tag. When both hit the same tag in one cycle, the clear wins. A source whose bit is set at dispatch is available at once.
- R4: When wk_valid is 1, every queued source equal to wk_tag becomes available from the next cycle.
- R5: A source dispatched in the same cycle as a wakeup of its tag counts as available.
- R6: An entry is ready when each of its sources is either unused (its disp_src_vld bit is 0) or available. Only ready entries issue, and at the earliest in the cycle after they are written.
- R7: The class codes are 0 integer, 1 floating point, 2 branch and 3 reserved (never issues). At most 2 integer, 1 floating-point and 1 branch instruction issue per cycle, and at most 3 in total. Picking walks the ready entries from oldest to youngest and takes each one whose class cap and the total cap still have room.
- R8: Sequence a is older than b when bit 7 of (a - b) mod 256 is 1. Slot 0 carries the oldest issued entry, and each further slot a younger one.
- R9: An entry shown on an issue slot is freed at the next clock edge.
- R10: When squash_valid is 1, every entry whose sequence number is younger than squash_seq is removed at the next edge. Entries equal to or older than squash_seq stay.
- R11: In a squash cycle no slot issues and the dispatch is dropped. The wakeup still applies to the scoreboard and to the surviving entries.
- R12: Each issue slot outputs valid, class, sequence number, destination-valid and destination tag. A slot whose valid bit is 0 drives zero on every other field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | 8 | Sequence number of the dispatched instruction |
| disp_cls | input | 2 | Class code |
| disp_src_vld | input | 2 | Per-source use flags |
| disp_src | input | 2x8 | Source physical tags |
| disp_dst_vld | input | 1 | Instruction writes a register |
| disp_dst | input | 8 | Destination physical tag |
| wk_valid | input | 1 | Completion wakeup strobe |
| wk_tag | input | 8 | Completed destination tag |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 8 | Youngest sequence number that survives |
| free_cnt | output | 5 | Number of empty entries |
| full | output | 1 | No entry is empty |
| iss_valid | output | 3 | Issue slot valid bits |
| iss_cls | output | 3x2 | Class per slot |
| iss_seq | output | 3x8 | Sequence number per slot |
| iss_dst_vld | output | 3 | Destination-valid per slot |
| iss_dst | output | 3x8 | Destination tag per slot |

## Verification
Some properties can be checked on every cycle: no slot issues during a squash, valid slots are packed from slot 0, per-class caps hold, slots are ordered by wraparound age, free_cnt is accounted from accepted dispatches and issues, and a full queue with nothing leaving stays full. The bench's scenarios are needed for the rest. Those cover which entries are picked when caps collide, the same-cycle wakeup capture at dispatch, the clear-versus-set race on one tag, the unified integer/floating-point tag split, the squash boundary at equal sequence numbers, and ordering across the 255-to-0 wrap.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int SEQ_W        = 8;
    localparam int TAG_W        = 8;
    localparam int NUM_INT_REGS = 96;
    localparam int NUM_FP_REGS  = 96;
    localparam int NUM_PREGS    = NUM_INT_REGS + NUM_FP_REGS;
    localparam int NUM_SRC      = 2;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_BR  = 2'd2,
        CLS_RSV = 2'd3
    } iq_cls_e;

    typedef struct packed {
        logic                             vld;
        logic [SEQ_W-1:0]                 seq;
        iq_cls_e                          cls;
        logic [NUM_SRC-1:0]               rdy;
        logic [NUM_SRC-1:0][TAG_W-1:0]    src;
        logic                             dst_vld;
        logic [TAG_W-1:0]                 dst;
    } iq_entry_t;

    // a is older than b when the wrapped difference is negative
    function automatic logic seq_is_older(input logic [SEQ_W-1:0] a,
                                          input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
    parameter int NUM_REGS = 192,
    parameter int TAG_W    = 8,
    parameter int NUM_RD   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_vld,
    input  logic [TAG_W-1:0]              set_tag,
    input  logic                          clr_vld,
    input  logic [TAG_W-1:0]              clr_tag,
    input  logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag,
    output logic [NUM_RD-1:0]             rd_avail
);
    typedef struct packed {
        logic [NUM_REGS-1:0] avail;
    } sb_state_t;

    sb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_vld && (int'(set_tag) < NUM_REGS)) st_d.avail[set_tag] = 1'b1;
        // a new producer overrides a completion of the same tag
        if (clr_vld && (int'(clr_tag) < NUM_REGS)) st_d.avail[clr_tag] = 1'b0;
        for (int r = 0; r < NUM_RD; r++) begin
            rd_avail[r] = ((int'(rd_tag[r]) < NUM_REGS) ? st_q.avail[rd_tag[r]] : 1'b1)
                        | (set_vld && (set_tag == rd_tag[r]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int INT_W = 2,
    parameter int FP_W  = 1,
    parameter int BR_W  = 1,
    parameter int TOT_W = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SLOT_W = (TOT_W > 1) ? $clog2(TOT_W) : 1
) (
    input  logic [DEPTH-1:0]              req,
    input  logic [DEPTH-1:0][SEQ_W-1:0]   seq,
    input  logic [DEPTH-1:0][1:0]         cls,
    output logic [DEPTH-1:0]              grant,
    output logic [DEPTH-1:0][SLOT_W-1:0]  slot
);
    // older_m[i][j]: entry j is older than entry i
    logic [DEPTH-1:0][DEPTH-1:0] older_m;
    logic [DEPTH-1:0]            elig;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
            if (gi == gj) begin : g_self
                assign older_m[gi][gj] = 1'b0;
            end else begin : g_pair
                assign older_m[gi][gj] = seq_is_older(seq[gj], seq[gi]);
            end
        end
    end

    function automatic logic [CNT_W-1:0] class_cap(input logic [1:0] c);
        case (c)
            2'd0:    return CNT_W'(INT_W);
            2'd1:    return CNT_W'(FP_W);
            2'd2:    return CNT_W'(BR_W);
            default: return '0;
        endcase
    endfunction

    // stage 1: the class cap, counted over older ready entries of the class
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [CNT_W-1:0] same_cnt;
            same_cnt = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (req[j] && older_m[i][j] && (cls[j] == cls[i]))
                    same_cnt = same_cnt + CNT_W'(1);
            end
            elig[i] = req[i] && (same_cnt < class_cap(cls[i]));
        end
    end

    // stage 2: the total cap, counted over older eligible entries
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [CNT_W-1:0] ecnt;
            ecnt = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (elig[j] && older_m[i][j]) ecnt = ecnt + CNT_W'(1);
            end
            grant[i] = elig[i] && (ecnt < CNT_W'(TOT_W));
            slot[i]  = ecnt[SLOT_W-1:0];
        end
    end
endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int INT_W = 2,
    parameter int FP_W  = 1,
    parameter int BR_W  = 1,
    parameter int TOT_W = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int SLOT_W = (TOT_W > 1) ? $clog2(TOT_W) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            disp_valid,
    input  logic [SEQ_W-1:0]                disp_seq,
    input  logic [1:0]                      disp_cls,
    input  logic [NUM_SRC-1:0]              disp_src_vld,
    input  logic [NUM_SRC-1:0][TAG_W-1:0]   disp_src,
    input  logic                            disp_dst_vld,
    input  logic [TAG_W-1:0]                disp_dst,
    input  logic                            wk_valid,
    input  logic [TAG_W-1:0]                wk_tag,
    input  logic                            squash_valid,
    input  logic [SEQ_W-1:0]                squash_seq,
    output logic [CNT_W-1:0]                free_cnt,
    output logic                            full,
    output logic [TOT_W-1:0]                iss_valid,
    output logic [TOT_W-1:0][1:0]           iss_cls,
    output logic [TOT_W-1:0][SEQ_W-1:0]     iss_seq,
    output logic [TOT_W-1:0]                iss_dst_vld,
    output logic [TOT_W-1:0][TAG_W-1:0]     iss_dst
);
    typedef struct packed {
        iq_entry_t [DEPTH-1:0] ent;
    } iq_state_t;

    iq_state_t st_d, st_q;

    logic [DEPTH-1:0]             req_v;
    logic [DEPTH-1:0][SEQ_W-1:0]  seq_v;
    logic [DEPTH-1:0][1:0]        cls_v;
    logic [DEPTH-1:0]             grant;
    logic [DEPTH-1:0][SLOT_W-1:0] slot;
    logic [CNT_W-1:0]             occ;
    logic [IDX_W-1:0]             free_idx;
    logic                         accept;
    logic [NUM_SRC-1:0]           src_avail;
    iq_entry_t                    new_ent;

    // per-entry view for the picker, plus occupancy and first free entry
    always_comb begin
        occ      = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            req_v[i] = st_q.ent[i].vld && (&st_q.ent[i].rdy) && !squash_valid;
            seq_v[i] = st_q.ent[i].seq;
            cls_v[i] = st_q.ent[i].cls;
            occ      = occ + CNT_W'(st_q.ent[i].vld);
            if (!st_q.ent[i].vld) free_idx = IDX_W'(i);
        end
        full     = (occ == CNT_W'(DEPTH));
        free_cnt = CNT_W'(DEPTH) - occ;
        accept   = disp_valid && !full && !squash_valid;
    end

    iq_scoreboard #(
        .NUM_REGS (NUM_PREGS),
        .TAG_W    (TAG_W),
        .NUM_RD   (NUM_SRC)
    ) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (wk_valid),
        .set_tag  (wk_tag),
        .clr_vld  (accept && disp_dst_vld),
        .clr_tag  (disp_dst),
        .rd_tag   (disp_src),
        .rd_avail (src_avail)
    );

    iq_select #(
        .DEPTH (DEPTH),
        .INT_W (INT_W),
        .FP_W  (FP_W),
        .BR_W  (BR_W),
        .TOT_W (TOT_W)
    ) u_sel (
        .req   (req_v),
        .seq   (seq_v),
        .cls   (cls_v),
        .grant (grant),
        .slot  (slot)
    );

    always_comb begin
        new_ent         = '0;
        new_ent.vld     = 1'b1;
        new_ent.seq     = disp_seq;
        new_ent.cls     = iq_cls_e'(disp_cls);
        new_ent.rdy     = ~disp_src_vld | src_avail;
        new_ent.src     = disp_src;
        new_ent.dst_vld = disp_dst_vld;
        new_ent.dst     = disp_dst;
    end

    // next state
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (st_q.ent[i].vld && wk_valid && (st_q.ent[i].src[s] == wk_tag))
                    st_d.ent[i].rdy[s] = 1'b1;
            end
        end
        if (squash_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (seq_is_older(squash_seq, st_q.ent[i].seq))
                    st_d.ent[i].vld = 1'b0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (grant[i]) st_d.ent[i].vld = 1'b0;
            end
            if (accept) st_d.ent[free_idx] = new_ent;
        end
    end

    // issue slot steering
    always_comb begin
        iss_valid   = '0;
        iss_cls     = '0;
        iss_seq     = '0;
        iss_dst_vld = '0;
        iss_dst     = '0;
        for (int k = 0; k < TOT_W; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (grant[i] && (slot[i] == SLOT_W'(k))) begin
                    iss_valid[k]   = 1'b1;
                    iss_cls[k]     = st_q.ent[i].cls;
                    iss_seq[k]     = st_q.ent[i].seq;
                    iss_dst_vld[k] = st_q.ent[i].dst_vld;
                    iss_dst[k]     = st_q.ent[i].dst;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/iq_issue_queue_chk.sv
module iq_issue_queue_chk
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int INT_W = 2,
    parameter int FP_W  = 1,
    parameter int BR_W  = 1,
    parameter int TOT_W = 3,
    parameter int CNT_W = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        disp_valid,
    input logic                        squash_valid,
    input logic                        full,
    input logic [CNT_W-1:0]            free_cnt,
    input logic [TOT_W-1:0]            iss_valid,
    input logic [TOT_W-1:0][1:0]       iss_cls,
    input logic [TOT_W-1:0][SEQ_W-1:0] iss_seq
);
    logic [TOT_W-1:0] int_v, fp_v, br_v;
    logic             packed_ok, order_ok;
    logic [CNT_W-1:0] free_nxt;

    always_comb begin
        int fn;
        packed_ok = 1'b1;
        order_ok  = 1'b1;
        for (int k = 0; k < TOT_W; k++) begin
            int_v[k] = iss_valid[k] && (iss_cls[k] == 2'd0);
            fp_v[k]  = iss_valid[k] && (iss_cls[k] == 2'd1);
            br_v[k]  = iss_valid[k] && (iss_cls[k] == 2'd2);
            if (k > 0) begin
                if (iss_valid[k] && !iss_valid[k-1]) packed_ok = 1'b0;
                if (iss_valid[k] && iss_valid[k-1] && !seq_is_older(iss_seq[k-1], iss_seq[k]))
                    order_ok = 1'b0;
            end
        end
        fn = int'(free_cnt) + $countones(iss_valid) - int'(disp_valid && !full && !squash_valid);
        free_nxt = CNT_W'(fn);
    end

    p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !squash_valid && (iss_valid == '0)) |=> full);

    p_class_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(int_v) <= INT_W) && ($countones(fp_v) <= FP_W) && ($countones(br_v) <= BR_W));

    p_slot_age_r8: assert property (@(posedge clk) disable iff (!rst_n) order_ok);

    p_free_account_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_valid |=> (free_cnt == $past(free_nxt)));

    p_squash_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> (free_cnt >= $past(free_cnt)));

    p_no_issue_on_squash_r11: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> (iss_valid == '0));

    p_slots_packed_r12: assert property (@(posedge clk) disable iff (!rst_n) packed_ok);
endmodule

bind iq_issue_queue iq_issue_queue_chk #(
    .DEPTH (DEPTH),
    .INT_W (INT_W),
    .FP_W  (FP_W),
    .BR_W  (BR_W),
    .TOT_W (TOT_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid   (disp_valid),
    .squash_valid (squash_valid),
    .full         (full),
    .free_cnt     (free_cnt),
    .iss_valid    (iss_valid),
    .iss_cls      (iss_cls),
    .iss_seq      (iss_seq)
);

// File: tb/tb_iq_issue_queue.sv
`timescale 1ns/1ps
module tb_iq_issue_queue;
    localparam int D = 16;
    localparam int T = 3;
    localparam int NREG = 192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             disp_valid = 0;
    logic [7:0]       disp_seq = 0;
    logic [1:0]       disp_cls = 0;
    logic [1:0]       disp_src_vld = 0;
    logic [1:0][7:0]  disp_src = 0;
    logic             disp_dst_vld = 0;
    logic [7:0]       disp_dst = 0;
    logic             wk_valid = 0;
    logic [7:0]       wk_tag = 0;
    logic             squash_valid = 0;
    logic [7:0]       squash_seq = 0;
    logic [4:0]       free_cnt;
    logic             full;
    logic [T-1:0]     iss_valid;
    logic [T-1:0][1:0] iss_cls;
    logic [T-1:0][7:0] iss_seq;
    logic [T-1:0]     iss_dst_vld;
    logic [T-1:0][7:0] iss_dst;

    iq_issue_queue dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_seq(disp_seq), .disp_cls(disp_cls),
        .disp_src_vld(disp_src_vld), .disp_src(disp_src),
        .disp_dst_vld(disp_dst_vld), .disp_dst(disp_dst),
        .wk_valid(wk_valid), .wk_tag(wk_tag),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .free_cnt(free_cnt), .full(full),
        .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_seq(iss_seq),
        .iss_dst_vld(iss_dst_vld), .iss_dst(iss_dst)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit         m_vld [D];
    logic [7:0] m_seq [D];
    logic [1:0] m_cls [D];
    bit         m_rdy [D][2];
    logic [7:0] m_src [D][2];
    bit         m_dv  [D];
    logic [7:0] m_dst [D];
    bit         m_sb  [NREG];
    logic [7:0] next_seq = 0;

    // stimulus for the next cycle
    bit b_dv, b_dstv, b_wk, b_sq;
    logic [1:0] b_cls, b_sv;
    logic [7:0] b_seq, b_s0, b_s1, b_dst, b_wkt, b_sqs;

    function automatic bit older(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] d;
        d = a - b;
        return d[7];
    endfunction

    function automatic int cap(input logic [1:0] c);
        case (c)
            2'd0: return 2;
            2'd1: return 1;
            2'd2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit sb_avail(input logic [7:0] t);
        if (int'(t) < NREG) return m_sb[t];
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        b_dv = 0; b_dstv = 0; b_wk = 0; b_sq = 0;
        b_cls = 0; b_sv = 0; b_seq = 0; b_s0 = 0; b_s1 = 0;
        b_dst = 0; b_wkt = 0; b_sqs = 0;
    endtask

    task automatic disp(input logic [1:0] c, input bit v0, input logic [7:0] s0,
                        input bit v1, input logic [7:0] s1, input bit dv, input logic [7:0] d);
        b_dv = 1; b_seq = next_seq; b_cls = c; b_sv = {v1, v0};
        b_s0 = s0; b_s1 = s1; b_dstv = dv; b_dst = d;
    endtask

    // one clock: drive, compare against model, advance model
    task automatic cycle(input string tag);
        int occ, fidx, tot;
        bit e_full, acc;
        bit consid [D];
        bit picked [D];
        int ccnt [4];
        bit e_v [T];
        int e_idx [T];
        @(negedge clk);
        disp_valid = b_dv; disp_seq = b_seq; disp_cls = b_cls; disp_src_vld = b_sv;
        disp_src[0] = b_s0; disp_src[1] = b_s1; disp_dst_vld = b_dstv; disp_dst = b_dst;
        wk_valid = b_wk; wk_tag = b_wkt; squash_valid = b_sq; squash_seq = b_sqs;
        #1;
        occ = 0; fidx = -1; tot = 0;
        for (int i = 0; i < D; i++) begin
            consid[i] = 0; picked[i] = 0;
            if (m_vld[i]) occ++;
            else if (fidx < 0) fidx = i;
        end
        for (int c = 0; c < 4; c++) ccnt[c] = 0;
        for (int s = 0; s < T; s++) begin e_v[s] = 0; e_idx[s] = 0; end
        e_full = (occ == D);
        acc = b_dv && !e_full && !b_sq;
        if (!b_sq) begin
            for (int k = 0; k < D; k++) begin
                int best = -1;
                for (int i = 0; i < D; i++)
                    if (m_vld[i] && m_rdy[i][0] && m_rdy[i][1] && !consid[i])
                        if (best < 0 || older(m_seq[i], m_seq[best])) best = i;
                if (best < 0) break;
                consid[best] = 1;
                if (tot < T && ccnt[m_cls[best]] < cap(m_cls[best])) begin
                    e_v[tot] = 1; e_idx[tot] = best; picked[best] = 1;
                    ccnt[m_cls[best]]++; tot++;
                end
            end
        end
        chk((free_cnt == 5'(D - occ)) && (full == e_full), "R2", "free_cnt/full",
            {free_cnt, full}, {5'(D - occ), e_full});
        for (int s = 0; s < T; s++) begin
            logic [19:0] a, e;
            a = {iss_valid[s], iss_cls[s], iss_seq[s], iss_dst_vld[s], iss_dst[s]};
            e = '0;
            if (e_v[s]) e = {1'b1, m_cls[e_idx[s]], m_seq[e_idx[s]], m_dv[e_idx[s]], m_dst[e_idx[s]]};
            chk(a == e, tag, $sformatf("issue slot %0d", s), a, e);
        end
        // model next state
        for (int i = 0; i < D; i++)
            for (int s = 0; s < 2; s++)
                if (m_vld[i] && b_wk && m_src[i][s] == b_wkt) m_rdy[i][s] = 1;
        if (b_sq) begin
            for (int i = 0; i < D; i++)
                if (m_vld[i] && older(b_sqs, m_seq[i])) m_vld[i] = 0;
        end else begin
            for (int i = 0; i < D; i++) if (picked[i]) m_vld[i] = 0;
            if (acc) begin
                m_vld[fidx] = 1; m_seq[fidx] = b_seq; m_cls[fidx] = b_cls;
                m_src[fidx][0] = b_s0; m_src[fidx][1] = b_s1;
                m_rdy[fidx][0] = !b_sv[0] || sb_avail(b_s0) || (b_wk && b_wkt == b_s0);
                m_rdy[fidx][1] = !b_sv[1] || sb_avail(b_s1) || (b_wk && b_wkt == b_s1);
                m_dv[fidx] = b_dstv; m_dst[fidx] = b_dst;
            end
        end
        if (b_wk && int'(b_wkt) < NREG) m_sb[b_wkt] = 1;
        if (acc && b_dstv && int'(b_dst) < NREG) m_sb[b_dst] = 0;
        if (acc) next_seq = next_seq + 8'd1;
        idle_inputs();
    endtask

    function automatic logic [7:0] pick_tag();
        int r;
        r = int'($urandom % 12);
        if (r < 5)   return 8'(r);
        if (r == 5)  return 8'd95;
        if (r == 6)  return 8'd96;
        if (r == 11) return 8'd191;
        return 8'(96 + r);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < D; i++) m_vld[i] = 0;
        for (int i = 0; i < NREG; i++) m_sb[i] = 1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(free_cnt == 5'd16, "R1", "free_cnt after reset", free_cnt, 16);
        chk(full == 1'b0, "R1", "full after reset", full, 0);
        chk(iss_valid == '0, "R1", "iss_valid after reset", iss_valid, 0);

        // R3: unified tags, FP producer 96, integer tag 95 untouched
        disp(2'd1, 0, 0, 0, 0, 1, 8'd96); cycle("R3");
        cycle("R3");
        disp(2'd0, 1, 8'd96, 0, 0, 1, 8'd10); cycle("R3");
        disp(2'd0, 1, 8'd95, 0, 0, 1, 8'd11); cycle("R3");
        cycle("R3 R6"); cycle("R3 R6");
        // R5: dispatch consumer of 96 while 96 wakes
        b_wk = 1; b_wkt = 8'd96;
        disp(2'd2, 1, 8'd96, 0, 0, 0, 8'd0); cycle("R5");
        cycle("R4 R5"); cycle("R5");
        // R3: producer of 50 clears while 50 wakes in the same cycle
        b_wk = 1; b_wkt = 8'd50;
        disp(2'd0, 0, 0, 0, 0, 1, 8'd50); cycle("R3");
        disp(2'd0, 1, 8'd50, 0, 0, 0, 8'd0); cycle("R3");
        cycle("R3"); cycle("R3");
        b_wk = 1; b_wkt = 8'd50; cycle("R4");
        cycle("R4"); cycle("R4");

        // R2: fill with waiters on tag 7, then offer more while full
        disp(2'd0, 0, 0, 0, 0, 1, 8'd7); cycle("R2");
        for (int i = 0; i < 19; i++) begin
            disp(2'(i % 3), 1, 8'd7, (i % 4) == 0, 8'd191, 1, 8'(20 + i));
            cycle("R2");
        end
        cycle("R2");
        b_wk = 1; b_wkt = 8'd191; cycle("R4");
        b_wk = 1; b_wkt = 8'd7;   cycle("R4");
        for (int i = 0; i < 10; i++) cycle("R7 R9");

        // R8: sequence numbers across the wrap
        next_seq = 8'd252;
        disp(2'd0, 0, 0, 0, 0, 1, 8'd3); cycle("R8");
        for (int i = 0; i < 5; i++) begin
            disp(2'(i == 2 ? 1 : 0), 1, 8'd3, 0, 0, 1, 8'(30 + i));
            cycle("R8");
        end
        b_wk = 1; b_wkt = 8'd3; cycle("R8");
        for (int i = 0; i < 5; i++) cycle("R7 R8");

        // R10 R11: squash with a dispatch and a wakeup in the same cycle
        disp(2'd0, 0, 0, 0, 0, 1, 8'd4); cycle("R10");
        for (int i = 0; i < 6; i++) begin
            disp(2'(i % 3), 1, 8'd4, 0, 0, 1, 8'(40 + i));
            cycle("R10");
        end
        begin
            logic [7:0] keep;
            keep = next_seq - 8'd4;
            b_sq = 1; b_sqs = keep; b_wk = 1; b_wkt = 8'd4;
            disp(2'd0, 0, 0, 0, 0, 0, 8'd0);
            cycle("R10 R11");
            next_seq = keep + 8'd1;
        end
        for (int i = 0; i < 6; i++) cycle("R10 R12");

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 10) < 7)
                disp(2'($urandom % 3), ($urandom % 3) != 0, pick_tag(),
                     ($urandom % 2) != 0, pick_tag(), ($urandom % 5) != 0, pick_tag());
            if (($urandom % 2) != 0) begin b_wk = 1; b_wkt = pick_tag(); end
            if (($urandom % 40) == 0) begin
                logic [7:0] keep;
                keep = next_seq - 8'd1 - 8'($urandom % 6);
                b_sq = 1; b_sqs = keep;
                cycle("R10 R11");
                next_seq = keep + 8'd1;
            end else begin
                cycle("R6 R7 R12");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule